// File: doc/BRIEF.md
# XOR-combined high-resolution PWM generator

This block produces PWM waveforms whose pulse edges are placed with single fine-tick precision, including pulses narrower than one coarse loop period. A timebase divides the fine clock by a programmable ratio to form loop periods, and a loop counter runs from zero to a programmable maximum and then restarts. The PWM period is therefore (maximum + 1) × ratio fine ticks. Each of two edge channels (even and odd) is raised at the start of every period. It compares the loop counter against its coarse value, then counts down its fine value in fine ticks and pulls its output low. The scheduled edge time is coarse × ratio + fine.

In XOR mode the even pin carries the exclusive-OR of the two channels. It is high between the two edge times, so both edges of a pulse come from independent fine-delay channels and a centred or very short pulse needs no special handling. The odd pin is then handed to a general-purpose output value. In split mode each pin carries its own channel. Compare values are written into per-channel shadow registers and take effect at the next period boundary. The counter maximum and the ratio are captured at reset and at every period boundary.

Top module: `xedge_pwm`

## Requirements
- R1: The period is (cnt_max_i + 1) × ratio_i fine clock cycles. In split mode with an even compare of coarse 0 / fine 0, the even pin rises once per period, so successive rises lie exactly one period apart.
- R2: One loop period lasts ratio_i fine cycles. Changing the ratio changes the period length accordingly. With maximum 4 and ratio 3 the period is 15 cycles.
- R3: Number the fine cycles of a period t = 0 .. P-1, starting at the first cycle after a boundary. A channel with edge time E = coarse × ratio + fine (fine < ratio, coarse ≤ maximum) is high for t ≤ E and low for t > E. With E = P-1 it stays high for the whole period.
- R4: A channel output rises only at the first cycle of a period, never in the middle of one.
- R5: In XOR mode the even pin equals even channel XOR odd channel. It is high for |E_even − E_odd| cycles per period. With maximum 22, ratio 128 and compares 17/115 and 5/13, that is 1638 of 2944 cycles.
- R6: A compare write (strobe high for one cycle) goes to a shadow register. The edge of the current period still follows the previous value, and the new value governs from the next period on.
- R7: When both channels fall on the same fine cycle, the toggles cancel and the XOR output does not change.
- R8: mode_xor_i = 1 selects XOR mode, in which the odd pin follows gpio_i. mode_xor_i = 0 selects split mode, in which the even pin carries the even channel and the odd pin the odd channel.
- R9: A synchronous reset clears the counters, the fine-delay counters, both channel outputs and the compare registers. Both channels stay low for the whole first period after reset.
- R10: cnt_max_i and ratio_i are sampled at reset and at every period boundary. A change in the middle of a period leaves that period's length and edge positions unchanged.
- R11: A coarse value above the counter maximum never matches, so that channel stays high for the whole period. Fine values written must be below ratio_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine (high-resolution) clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_max_i | input | CNT_W | Loop counter maximum (period = max+1 loop periods) |
| ratio_i | input | PRE_W | Fine ticks per loop period, nonzero |
| mode_xor_i | input | 1 | 1 = XOR-shared output, 0 = split outputs |
| ev_wr_i | input | 1 | Write strobe for the even channel compare shadow |
| ev_coarse_i | input | CNT_W | Even channel coarse compare value |
| ev_fine_i | input | PRE_W | Even channel fine delay |
| od_wr_i | input | 1 | Write strobe for the odd channel compare shadow |
| od_coarse_i | input | CNT_W | Odd channel coarse compare value |
| od_fine_i | input | PRE_W | Odd channel fine delay |
| gpio_i | input | 1 | General-purpose value driven on the odd pin in XOR mode |
| pin_even_o | output | 1 | Even pin: XOR of channels, or even channel alone |
| pin_odd_o | output | 1 | Odd pin: gpio_i in XOR mode, or odd channel alone |

## Verification
The assertions take for granted that ratio_i is never zero and that every fine value written is below the ratio in force on the write cycle. Without that, a fine delay could run past its loop slot and across the period boundary. The stimulus only uses ratios of 3, 4 and 128. It writes fine values taken modulo the small ratio, or 115 and 13 under ratio 128. It switches the ratio only after the compares already in the shadows are valid for the new value. The sweep over every pair of edge positions in a 16-cycle period covers the equal-edge cancellation case and the edge at the last cycle of a period.

// File: rtl/xep_pkg.sv
package xep_pkg;

    typedef enum logic {
        PIN_SPLIT = 1'b0,
        PIN_XOR   = 1'b1
    } pin_mode_e;

    localparam int NUM_CHAN = 2;

endpackage

// File: rtl/xep_timebase.sv
module xep_timebase #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] max_i,
    input  logic [PRE_W-1:0] ratio_i,
    output logic [CNT_W-1:0] loop_o,
    output logic             slot0_o,
    output logic             wrap_o
);

    localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);
    localparam logic [CNT_W-1:0] LOOP_ONE = CNT_W'(1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] loop;
        logic [PRE_W-1:0] ratio;
        logic [CNT_W-1:0] maxc;
    } tb_state_t;

    tb_state_t s_d, s_q;
    logic      slot_end_d;
    logic      wrap_d;

    always_comb begin
        s_d        = s_q;
        slot_end_d = (s_q.pre == (s_q.ratio - PRE_ONE));
        wrap_d     = slot_end_d && (s_q.loop == s_q.maxc);
        if (rst) begin
            s_d.pre   = '0;
            s_d.loop  = '0;
            s_d.ratio = ratio_i;
            s_d.maxc  = max_i;
        end else if (wrap_d) begin
            s_d.pre   = '0;
            s_d.loop  = '0;
            s_d.ratio = ratio_i;
            s_d.maxc  = max_i;
        end else if (slot_end_d) begin
            s_d.pre  = '0;
            s_d.loop = s_q.loop + LOOP_ONE;
        end else begin
            s_d.pre = s_q.pre + PRE_ONE;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign loop_o  = s_q.loop;
    assign slot0_o = (s_q.pre == '0);
    assign wrap_o  = wrap_d && !rst;

    // R1: loop counter never passes the captured maximum
    p_loop_bound_r1: assert property (@(posedge clk) disable iff (rst)
        s_q.loop <= s_q.maxc);

    // R1: a period boundary restarts both counters
    p_wrap_restart_r1: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (s_q.loop == '0) && (s_q.pre == '0));

    // R2: prescaler stays inside one loop period
    p_pre_bound_r2: assert property (@(posedge clk) disable iff (rst)
        s_q.pre < s_q.ratio);

    // R2: the ratio supplied must be nonzero
    p_ratio_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        ratio_i != '0);

    // R10: captured configuration only changes at a boundary
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wrap_o |=> $stable(s_q.ratio) && $stable(s_q.maxc));

endmodule

// File: rtl/xep_edge_chan.sv
module xep_edge_chan #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wrap_i,
    input  logic             slot0_i,
    input  logic [CNT_W-1:0] loop_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] coarse_i,
    input  logic [PRE_W-1:0] fine_i,
    output logic             out_o
);

    localparam logic [PRE_W-1:0] FINE_ONE = PRE_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] shd_c;
        logic [PRE_W-1:0] shd_f;
        logic [CNT_W-1:0] act_c;
        logic [PRE_W-1:0] act_f;
        logic [PRE_W-1:0] cnt;
        logic             out;
    } ch_state_t;

    ch_state_t c_d, c_q;
    logic      hit_d;

    always_comb begin
        c_d   = c_q;
        hit_d = slot0_i && (loop_i == c_q.act_c);
        if (rst) begin
            c_d = '0;
        end else begin
            if (wrap_i) begin
                c_d.act_c = c_q.shd_c;
                c_d.act_f = c_q.shd_f;
                c_d.cnt   = '0;
                c_d.out   = 1'b1;
            end else if (hit_d) begin
                if (c_q.act_f == '0) begin
                    c_d.out = 1'b0;
                end else begin
                    c_d.cnt = c_q.act_f;
                end
            end else if (c_q.cnt != '0) begin
                c_d.cnt = c_q.cnt - FINE_ONE;
                if (c_q.cnt == FINE_ONE) begin
                    c_d.out = 1'b0;
                end
            end
            if (wr_i) begin
                c_d.shd_c = coarse_i;
                c_d.shd_f = fine_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign out_o = c_q.out;

    // R4: channel output only goes high on a period boundary
    p_rise_at_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(c_q.out) |-> $past(wrap_i));

    // R6: active compare only changes on a period boundary
    p_shadow_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wrap_i |=> $stable(c_q.act_c) && $stable(c_q.act_f));

    // R3: a running fine delay is always finished before the next boundary
    p_delay_done_r3: assert property (@(posedge clk) disable iff (rst)
        wrap_i |-> (c_q.cnt == '0) || (c_q.cnt == FINE_ONE));

endmodule

// File: rtl/xep_pin_mux.sv
module xep_pin_mux
    import xep_pkg::*;
(
    input  pin_mode_e mode_i,
    input  logic      ch_even_i,
    input  logic      ch_odd_i,
    input  logic      gpio_i,
    output logic      pin_even_o,
    output logic      pin_odd_o
);

    always_comb begin
        if (mode_i == PIN_XOR) begin
            pin_even_o = ch_even_i ^ ch_odd_i;
            pin_odd_o  = gpio_i;
        end else begin
            pin_even_o = ch_even_i;
            pin_odd_o  = ch_odd_i;
        end
    end

endmodule

// File: rtl/xedge_pwm.sv
module xedge_pwm
    import xep_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_max_i,
    input  logic [PRE_W-1:0] ratio_i,
    input  logic             mode_xor_i,
    input  logic             ev_wr_i,
    input  logic [CNT_W-1:0] ev_coarse_i,
    input  logic [PRE_W-1:0] ev_fine_i,
    input  logic             od_wr_i,
    input  logic [CNT_W-1:0] od_coarse_i,
    input  logic [PRE_W-1:0] od_fine_i,
    input  logic             gpio_i,
    output logic             pin_even_o,
    output logic             pin_odd_o
);

    logic [CNT_W-1:0] loop_w;
    logic             slot0_w;
    logic             wrap_w;

    logic             wr_v   [NUM_CHAN];
    logic [CNT_W-1:0] crs_v  [NUM_CHAN];
    logic [PRE_W-1:0] fin_v  [NUM_CHAN];
    logic             ch_out [NUM_CHAN];

    assign wr_v[0]  = ev_wr_i;
    assign crs_v[0] = ev_coarse_i;
    assign fin_v[0] = ev_fine_i;
    assign wr_v[1]  = od_wr_i;
    assign crs_v[1] = od_coarse_i;
    assign fin_v[1] = od_fine_i;

    xep_timebase #(
        .CNT_W (CNT_W),
        .PRE_W (PRE_W)
    ) u_timebase (
        .clk     (clk),
        .rst     (rst),
        .max_i   (cnt_max_i),
        .ratio_i (ratio_i),
        .loop_o  (loop_w),
        .slot0_o (slot0_w),
        .wrap_o  (wrap_w)
    );

    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
        xep_edge_chan #(
            .CNT_W (CNT_W),
            .PRE_W (PRE_W)
        ) u_chan (
            .clk      (clk),
            .rst      (rst),
            .wrap_i   (wrap_w),
            .slot0_i  (slot0_w),
            .loop_i   (loop_w),
            .wr_i     (wr_v[g]),
            .coarse_i (crs_v[g]),
            .fine_i   (fin_v[g]),
            .out_o    (ch_out[g])
        );
    end

    xep_pin_mux u_mux (
        .mode_i     (pin_mode_e'(mode_xor_i)),
        .ch_even_i  (ch_out[0]),
        .ch_odd_i   (ch_out[1]),
        .gpio_i     (gpio_i),
        .pin_even_o (pin_even_o),
        .pin_odd_o  (pin_odd_o)
    );

    // R7: simultaneous falls of both channels leave the XOR pin unchanged
    p_cancel_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_xor_i && $past(mode_xor_i) && $fell(ch_out[0]) && $fell(ch_out[1]))
        |-> $stable(pin_even_o));

    // R8: in XOR mode the odd pin moves only with gpio_i
    p_odd_gpio_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_xor_i && $past(mode_xor_i) && $stable(gpio_i)) |-> $stable(pin_odd_o));

    // R9: both pins are low right after a reset in split mode
    p_reset_low_r9: assert property (@(posedge clk)
        ($past(rst) && !mode_xor_i) |-> (!pin_even_o && !pin_odd_o));

    // R11: written fine values stay below the ratio
    p_fine_range_r11: assert property (@(posedge clk) disable iff (rst)
        (ev_wr_i |-> ev_fine_i < ratio_i) and (od_wr_i |-> od_fine_i < ratio_i));

endmodule

// File: tb/xedge_pwm_test.sv
module xedge_pwm_test;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cmax = '0;
    logic [PW-1:0] ratio = PW'(4);
    logic          mode = 1'b1;
    logic          ev_wr = 1'b0, od_wr = 1'b0;
    logic [CW-1:0] ev_c = '0, od_c = '0;
    logic [PW-1:0] ev_f = '0, od_f = '0;
    logic          gpio = 1'b0;
    logic          pin0, pin1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xedge_pwm #(.CNT_W(CW), .PRE_W(PW)) uut (
        .clk(clk), .rst(rst), .cnt_max_i(cmax), .ratio_i(ratio),
        .mode_xor_i(mode),
        .ev_wr_i(ev_wr), .ev_coarse_i(ev_c), .ev_fine_i(ev_f),
        .od_wr_i(od_wr), .od_coarse_i(od_c), .od_fine_i(od_f),
        .gpio_i(gpio), .pin_even_o(pin0), .pin_odd_o(pin1)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;
    int m_t, m_per, m_ratio, m_max;
    int m_sc[2], m_sf[2], m_ac[2], m_af[2];
    int hi0, hi1;
    logic prev0;

    task automatic model_edge();
        int p;
        if (rst) begin
            m_t = 0; m_per = 0; m_ratio = int'(ratio); m_max = int'(cmax);
            for (int i = 0; i < 2; i++) begin
                m_sc[i] = 0; m_sf[i] = 0; m_ac[i] = 0; m_af[i] = 0;
            end
        end else begin
            p = (m_max + 1) * m_ratio;
            if (m_t == p - 1) begin
                for (int i = 0; i < 2; i++) begin
                    m_ac[i] = m_sc[i]; m_af[i] = m_sf[i];
                end
                m_t = 0; m_per++;
                m_ratio = int'(ratio); m_max = int'(cmax);
            end else begin
                m_t++;
            end
            if (ev_wr) begin m_sc[0] = int'(ev_c); m_sf[0] = int'(ev_f); end
            if (od_wr) begin m_sc[1] = int'(od_c); m_sf[1] = int'(od_f); end
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    function automatic int exp_ch(int i);
        int e;
        if (m_per == 0) return 0;
        e = (m_ac[i] <= m_max) ? m_ac[i] * m_ratio + m_af[i] : 32'h3fff_ffff;
        return (m_t <= e) ? 1 : 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d (t=%0d period=%0d)", tag, act, exp, m_t, m_per);
        end
    endtask

    task automatic check_pins(string tag);
        int a, b, e0, e1;
        string tg;
        a  = exp_ch(0);
        b  = exp_ch(1);
        tg = (m_per == 0) ? "R9" : tag;
        e0 = mode ? (a ^ b) : a;
        e1 = mode ? int'(gpio) : b;
        check(tg, int'(pin0), e0);
        check(mode ? "R8" : tg, int'(pin1), e1);
    endtask

    task automatic run(int n, string tag);
        for (int k = 0; k < n; k++) begin
            gpio = ~gpio;
            cyc();
            check_pins(tag);
            if (!mode && prev0 == 1'b0 && pin0 == 1'b1) check("R4", m_t, 0);
            prev0 = pin0;
            hi0 += int'(pin0);
            hi1 += int'(pin1);
        end
    endtask

    task automatic wait_start(string tag);
        while (m_t != 0) run(1, tag);
    endtask

    task automatic write_cmp(int ec, int ef, int oc, int of, string tag);
        ev_wr = 1'b1; ev_c = CW'(ec); ev_f = PW'(ef);
        od_wr = 1'b1; od_c = CW'(oc); od_f = PW'(of);
        run(1, tag);
        ev_wr = 1'b0; od_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int n;
        prev0 = 1'b1;
        // R9: reset state
        rst = 1'b1; cmax = CW'(3); ratio = PW'(4); mode = 1'b1; gpio = 1'b0;
        @(negedge clk);
        repeat (3) cyc();
        check("R9", int'(pin0), 0);
        check("R9", int'(pin1), 0);
        rst = 1'b0;
        run(16, "R9");

        // R5 / R7 / R6: all edge pairs in a 16-cycle period, XOR mode
        for (int ea = 0; ea < 16; ea++) begin
            for (int eb = 0; eb < 16; eb++) begin
                wait_start("R5");
                write_cmp(ea / 4, ea % 4, eb / 4, eb % 4, "R6");
                wait_start("R6");
                hi0 = 0;
                run(16, (ea == eb) ? "R7" : "R5");
                check((ea == eb) ? "R7" : "R5", hi0, (ea > eb) ? ea - eb : eb - ea);
            end
        end

        // R3 / R4: split mode, each channel alone, including E = P-1
        mode = 1'b0; prev0 = 1'b1;
        for (int ea = 0; ea < 16; ea++) begin
            wait_start("R3");
            write_cmp(ea / 4, ea % 4, (15 - ea) / 4, (15 - ea) % 4, "R6");
            wait_start("R6");
            hi0 = 0; hi1 = 0;
            run(16, "R3");
            check("R3", hi0, ea + 1);
            check("R3", hi1, 16 - ea);
        end

        // R11: coarse above the maximum never matches
        wait_start("R11");
        write_cmp(5, 0, 0, 0, "R11");
        wait_start("R11");
        hi0 = 0;
        run(16, "R11");
        check("R11", hi0, 16);

        // R1: rise-to-rise distance with edge at t=0
        wait_start("R1");
        write_cmp(0, 0, 0, 0, "R1");
        wait_start("R1");
        run(16, "R1");
        wait_start("R1");
        n = 0;
        do begin run(1, "R1"); n++; end while (!(pin0 == 1'b1 && prev0 == 1'b1 && n > 1) && pin0 != 1'b1 || n == 1 && pin0 == 1'b1 && 0);
        check("R1", n, 16);

        // R10 / R2: change config mid-period, takes effect at the boundary
        wait_start("R10");
        run(5, "R10");
        cmax = CW'(4); ratio = PW'(3);
        wait_start("R10");
        run(15, "R2");
        wait_start("R2");
        n = 0;
        do begin run(1, "R2"); n++; end while (pin0 != 1'b1);
        check("R2", n, 15);

        // R5: wide example period in XOR mode
        mode = 1'b1;
        wait_start("R10");
        cmax = CW'(22); ratio = PW'(128);
        write_cmp(17, 115, 5, 13, "R10");
        wait_start("R10");
        hi0 = 0;
        run(2944, "R5");
        check("R5", hi0, 1638);
        check("R1", m_t, 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule